// File: doc/BRIEF.md
# I/O Page Register Slave for a Multiplexed Backplane

This block is the slave side of a 22-bit multiplexed address/data backplane. It serves transfers only in the I/O page. A master begins each bus cycle by placing an address on the shared lines and asserting a sync strobe. The block catches the address at that moment and checks for the I/O-page qualifier. It compares a narrow address slice against a base value set by switches, and so claims a 32-byte window. Once claimed, the cycle may carry a read strobe, a write strobe, or a read followed by a write. The block answers every strobe with a reply line. The reply drops only after the master has removed the strobe. All bus lines are active-high here, because the inverting transceivers sit outside the block.

Behind the window sits a register file of sixteen 16-bit words. A write stores a full word, or one byte when the write/byte line is asserted during the data phase. A read drives the selected word onto the data lines together with reply. The block keeps driving for a short, fixed number of clocks after reply falls, then releases the lines. The sync, read and write strobes arrive asynchronously and each passes through a two-flop synchronizer.

The bus has no separate valid/ready pair. The strobe acts as valid and reply acts as ready. The master applies back-pressure simply by holding its strobe, and the block holds reply, and any read data, for as long as the strobe stays asserted.

Top module: `iopage_slave`

## Requirements
- R1: After `bus_init`, `reply`, `dal_oe` and `dal_out` are 0 and every register word reads as 0x0000.
- R2: The address, the I/O-page qualifier and the window decision are taken only in the clock where the synchronized sync strobe rises. Changes on `dal_in` after that point do not change which register is used.
- R3: A cycle is claimed only if `bus_iopage` is 1 when sync rises. Address bits 21:13 play no part in the decode.
- R4: A cycle is claimed only if `dal_in[12:5]` equals `base_sel`. On a mismatch no strobe is answered and `dal_oe` stays 0.
- R5: For a claimed read, `reply` and `dal_oe` rise in the same clock. `dal_out[15:0]` then carries the word chosen by address bits 4:1, `dal_out[21:16]` is 0, and both stay steady while the read strobe is held.
- R6: `reply` falls only after the synchronized read strobe is low. `dal_oe` then stays high for exactly `RELEASE_CYCLES` clocks (default 2, which is 10 ns at 200 MHz, inside the 100 ns limit) before it falls.
- R7: For a claimed write without the byte qualifier, `dal_in[15:0]` is stored in the word chosen by address bits 4:1, and `reply` rises. `reply` stays high until the write strobe is negated and falls afterwards.
- R8: When `bus_wtbt` is 1 while the write strobe is asserted, only one byte is written. Address bit 0 = 0 writes bits 7:0 from `dal_in[7:0]`. Address bit 0 = 1 writes bits 15:8 from `dal_in[15:8]`. The other byte is kept.
- R9: Strobes in a cycle that was not claimed get no reply and leave every register unchanged.
- R10: The claim ends when the sync strobe is negated. A strobe that follows without a new address phase gets no reply.
- R11: `bus_init` in the middle of a handshake drops `reply` and `dal_oe` at the next clock and clears all registers and the claim.
- R12: Within one claimed sync period, a read followed by a write (read-modify-write) answers both strobes and stores the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| bus_init | input | 1 | Bus reset, active high, synchronous |
| bus_sync | input | 1 | Address-phase strobe from master (asynchronous) |
| bus_iopage | input | 1 | I/O-page qualifier, sampled at sync rise |
| bus_wtbt | input | 1 | Write/byte line; selects a byte write during the data phase |
| bus_din | input | 1 | Read strobe (asynchronous) |
| bus_dout | input | 1 | Write strobe (asynchronous) |
| dal_in | input | 22 | Address/data lines as received |
| base_sel | input | 8 | Switch-set window base compared with address bits 12:5 |
| reply | output | 1 | Slave reply handshake |
| dal_oe | output | 1 | Enable for the data-line drivers |
| dal_out | output | 22 | Read data for the data lines |

## Verification
Two events can fall in the same clock: bus reset and a handshake in progress. The bench starts a write and waits until reply is high. It then raises `bus_init` while the write strobe is still held. The result is judged at the ports. Reply and the driver enable must be low one clock later, no reply may return while the strobe is still held, and a fresh read of the written word must return zero. A second case comes from the end of a read: a new write strobe inside the same sync period must wait until the driver release has finished.

// File: rtl/iopage_pkg.sv
package iopage_pkg;
  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_READ    = 2'd1,
    HS_WRITE   = 2'd2,
    HS_RELEASE = 2'd3
  } hs_state_t;
endpackage

// File: rtl/iopage_sync2.sv
module iopage_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         init,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (init) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/iopage_addr_latch.sv
module iopage_addr_latch #(
  parameter int BASE_W = 8,
  parameter int IDX_W  = 4,
  localparam int LOW_W = BASE_W + IDX_W + 1
) (
  input  logic              clk,
  input  logic              init,
  input  logic              sync_rise,
  input  logic              sync_s,
  input  logic              iopage,
  input  logic [LOW_W-1:0]  addr_lo,
  input  logic [BASE_W-1:0] base,
  output logic              sel_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              lane_q
);
  logic hit;
  assign hit = iopage && (addr_lo[LOW_W-1:IDX_W+1] == base);

  always_ff @(posedge clk) begin
    if (init) begin
      sel_q  <= 1'b0;
      idx_q  <= '0;
      lane_q <= 1'b0;
    end else if (sync_rise) begin
      sel_q  <= hit;
      idx_q  <= addr_lo[IDX_W:1];
      lane_q <= addr_lo[0];
    end else if (!sync_s) begin
      sel_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/iopage_regfile.sv
module iopage_regfile #(
  parameter int WORDS  = 16,
  parameter int DATA_W = 16,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              init,
  input  logic              wr_en,
  input  logic              byte_en,
  input  logic              lane_hi,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit_w;
    assign hit_w = wr_en && (idx == IDX_W'(w));
    always_ff @(posedge clk) begin
      if (init) begin
        mem[w] <= '0;
      end else if (hit_w) begin
        if (!byte_en || !lane_hi) mem[w][HALF_W-1:0]      <= wdata[HALF_W-1:0];
        if (!byte_en ||  lane_hi) mem[w][DATA_W-1:HALF_W] <= wdata[DATA_W-1:HALF_W];
      end
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/iopage_slave.sv
module iopage_slave
  import iopage_pkg::*;
#(
  parameter int DAL_W          = 22,
  parameter int DATA_W         = 16,
  parameter int BASE_W         = 8,
  parameter int WORDS          = 16,
  parameter int RELEASE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              bus_init,
  input  logic              bus_sync,
  input  logic              bus_iopage,
  input  logic              bus_wtbt,
  input  logic              bus_din,
  input  logic              bus_dout,
  input  logic [DAL_W-1:0]  dal_in,
  input  logic [BASE_W-1:0] base_sel,
  output logic              reply,
  output logic              dal_oe,
  output logic [DAL_W-1:0]  dal_out
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int LOW_W = BASE_W + IDX_W + 1;
  localparam int CNT_W = $clog2(RELEASE_CYCLES + 1);

  logic unused_hi;
  assign unused_hi = ^dal_in[DAL_W-1:DATA_W];

  // strobe synchronizers
  logic [2:0] strb_s;
  logic       sync_s, din_s, dout_s, sync_d, sync_rise;

  iopage_sync2 #(.W(3)) u_sync (
    .clk (clk),
    .init(bus_init),
    .d   ({bus_sync, bus_din, bus_dout}),
    .q   (strb_s)
  );
  assign {sync_s, din_s, dout_s} = strb_s;

  always_ff @(posedge clk) begin
    if (bus_init) sync_d <= 1'b0;
    else          sync_d <= sync_s;
  end
  assign sync_rise = sync_s && !sync_d;

  // address phase
  logic             sel_q, lane_q;
  logic [IDX_W-1:0] idx_q;

  iopage_addr_latch #(.BASE_W(BASE_W), .IDX_W(IDX_W)) u_addr (
    .clk      (clk),
    .init     (bus_init),
    .sync_rise(sync_rise),
    .sync_s   (sync_s),
    .iopage   (bus_iopage),
    .addr_lo  (dal_in[LOW_W-1:0]),
    .base     (base_sel),
    .sel_q    (sel_q),
    .idx_q    (idx_q),
    .lane_q   (lane_q)
  );

  // register file
  hs_state_t         state;
  logic              wr_en;
  logic [DATA_W-1:0] rdata;

  assign wr_en = (state == HS_IDLE) && sel_q && !din_s && dout_s;

  iopage_regfile #(.WORDS(WORDS), .DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .init   (bus_init),
    .wr_en  (wr_en),
    .byte_en(bus_wtbt),
    .lane_hi(lane_q),
    .idx    (idx_q),
    .wdata  (dal_in[DATA_W-1:0]),
    .rdata  (rdata)
  );

  // reply handshake
  logic [CNT_W-1:0] rel_cnt;

  always_ff @(posedge clk) begin
    if (bus_init) begin
      state   <= HS_IDLE;
      reply   <= 1'b0;
      dal_oe  <= 1'b0;
      dal_out <= '0;
      rel_cnt <= '0;
    end else begin
      unique case (state)
        HS_IDLE: begin
          if (sel_q && din_s) begin
            reply   <= 1'b1;
            dal_oe  <= 1'b1;
            dal_out <= {{(DAL_W-DATA_W){1'b0}}, rdata};
            state   <= HS_READ;
          end else if (sel_q && dout_s) begin
            reply <= 1'b1;
            state <= HS_WRITE;
          end
        end
        HS_READ: begin
          if (!din_s) begin
            reply   <= 1'b0;
            rel_cnt <= CNT_W'(RELEASE_CYCLES);
            state   <= HS_RELEASE;
          end
        end
        HS_WRITE: begin
          if (!dout_s) begin
            reply <= 1'b0;
            state <= HS_IDLE;
          end
        end
        HS_RELEASE: begin
          if (rel_cnt <= CNT_W'(1)) begin
            dal_oe  <= 1'b0;
            dal_out <= '0;
            rel_cnt <= '0;
            state   <= HS_IDLE;
          end else begin
            rel_cnt <= rel_cnt - CNT_W'(1);
          end
        end
        default: state <= HS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iopage_slave_chk.sv
module iopage_slave_chk #(
  parameter int DAL_W          = 22,
  parameter int RELEASE_CYCLES = 2
) (
  input logic             clk,
  input logic             bus_init,
  input logic             reply,
  input logic             dal_oe,
  input logic [DAL_W-1:0] dal_out,
  input logic             din_s,
  input logic             dout_s,
  input logic             sel_q
);
  localparam int CW = $clog2(RELEASE_CYCLES + 2);
  logic [CW-1:0] tail_cnt;

  always_ff @(posedge clk) begin
    if (bus_init)              tail_cnt <= '0;
    else if (dal_oe && !reply) tail_cnt <= tail_cnt + CW'(1);
    else                       tail_cnt <= '0;
  end

  AST_REPLY_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (bus_init)
    $rose(reply) |-> sel_q); // R9

  AST_READ_DRIVES_WITH_REPLY: assert property (@(posedge clk) disable iff (bus_init)
    (reply && din_s) |-> dal_oe); // R5

  AST_READ_DATA_STEADY: assert property (@(posedge clk) disable iff (bus_init)
    (reply && din_s && $past(reply) && $past(din_s)) |-> $stable(dal_out)); // R5

  AST_REPLY_HELD_BY_STROBE: assert property (@(posedge clk) disable iff (bus_init)
    (reply && (din_s || dout_s)) |=> reply); // R7

  AST_REPLY_DROPS_AFTER_STROBE: assert property (@(posedge clk) disable iff (bus_init)
    (reply && !din_s && !dout_s) |=> !reply); // R6

  AST_RELEASE_BOUNDED: assert property (@(posedge clk) disable iff (bus_init)
    (dal_oe && !reply) |-> (tail_cnt < CW'(RELEASE_CYCLES))); // R6
endmodule

bind iopage_slave iopage_slave_chk #(
  .DAL_W(DAL_W),
  .RELEASE_CYCLES(RELEASE_CYCLES)
) u_chk (
  .clk     (clk),
  .bus_init(bus_init),
  .reply   (reply),
  .dal_oe  (dal_oe),
  .dal_out (dal_out),
  .din_s   (din_s),
  .dout_s  (dout_s),
  .sel_q   (sel_q)
);

// File: tb/iopage_slave_bench.sv
`timescale 1ns/1ps
module iopage_slave_bench;
  localparam logic [7:0] BASE = 8'hA5;
  localparam int RELEASE = 2;

  logic        clk = 1'b0;
  logic        bus_init = 1'b1;
  logic        bus_sync = 1'b0, bus_iopage = 1'b0, bus_wtbt = 1'b0;
  logic        bus_din = 1'b0, bus_dout = 1'b0;
  logic [21:0] dal_in = '0;
  logic [7:0]  base_sel = BASE;
  logic        reply, dal_oe;
  logic [21:0] dal_out;

  always #2.5 clk = ~clk;

  iopage_slave u_iopage_slave (
    .clk(clk), .bus_init(bus_init), .bus_sync(bus_sync), .bus_iopage(bus_iopage),
    .bus_wtbt(bus_wtbt), .bus_din(bus_din), .bus_dout(bus_dout), .dal_in(dal_in),
    .base_sel(base_sel), .reply(reply), .dal_oe(dal_oe), .dal_out(dal_out)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] model [16];
  logic [21:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every read reply is compared with the queued expectation
  logic prev_reply = 1'b0;
  always @(negedge clk) begin
    if (reply && !prev_reply && bus_din) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected read reply", dal_out, 0);
      end else begin
        logic [21:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(dal_oe == 1'b1, t, "driver enable with reply", dal_oe, 1);
        check(dal_out == e, t, "read data", dal_out, e);
      end
    end
    prev_reply = reply;
  end

  function automatic logic [21:0] mk_addr(input logic [8:0] hi, input logic [7:0] base,
                                          input int idx, input bit lane);
    return {hi, base, idx[3:0], lane};
  endfunction

  task automatic wait_level(input bit lvl, input int limit, output bit got);
    got = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (reply == lvl) begin got = 1'b1; break; end
    end
  endtask

  task automatic addr_phase(input logic [21:0] a, input bit iop);
    @(negedge clk);
    dal_in = a; bus_iopage = iop; bus_wtbt = 1'b0;
    @(negedge clk);
    bus_sync = 1'b1;
    repeat (4) @(negedge clk);
    dal_in = '1;            // address lines move on after capture (R2)
    bus_iopage = 1'b0;
  endtask

  task automatic end_cycle();
    @(negedge clk);
    bus_sync = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read(input logic [15:0] exp, input string tag);
    bit got;
    logic [21:0] held;
    int n;
    exp_q.push_back({6'b0, exp});
    tag_q.push_back(tag);
    @(negedge clk);
    bus_din = 1'b1;
    wait_level(1'b1, 20, got);
    check(got, tag, "read reply seen", got, 1);
    held = dal_out;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(reply && dal_out == held, "R5", "reply and data held during strobe", dal_out, held);
    end
    bus_din = 1'b0;
    wait_level(1'b0, 20, got);
    check(got, "R6", "reply falls after strobe negation", reply, 0);
    n = 0;
    while (dal_oe && n < 20) begin n++; @(negedge clk); end
    check(n == RELEASE, "R6", "driver hold after reply fall", n, RELEASE);
  endtask

  task automatic do_write(input logic [15:0] data, input bit byte_w, input int idx,
                          input bit lane, input string tag);
    bit got;
    @(negedge clk);
    dal_in = {6'b0, data}; bus_wtbt = byte_w; bus_dout = 1'b1;
    wait_level(1'b1, 20, got);
    check(got, tag, "write reply seen", got, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(reply == 1'b1, "R7", "reply held while write strobe high", reply, 1);
    end
    bus_dout = 1'b0;
    wait_level(1'b0, 20, got);
    check(got, "R7", "reply falls after write strobe", reply, 0);
    bus_wtbt = 1'b0;
    if (!byte_w)   model[idx] = data;
    else if (lane) model[idx][15:8] = data[15:8];
    else           model[idx][7:0] = data[7:0];
  endtask

  task automatic expect_silent(input bit rd, input string tag);
    bit seen = 1'b0;
    @(negedge clk);
    dal_in = 22'h00DEAD;
    if (rd) bus_din = 1'b1; else bus_dout = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (reply || dal_oe) seen = 1'b1;
    end
    check(!seen, tag, "no reply to strobe", seen, 0);
    bus_din = 1'b0; bus_dout = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_word(input int idx, input string tag);
    addr_phase(mk_addr(9'h000, BASE, idx, 1'b0), 1'b1);
    do_read(model[idx], tag);
    end_cycle();
  endtask

  task automatic write_word(input int idx, input logic [15:0] d, input bit byte_w,
                            input bit lane, input string tag);
    addr_phase(mk_addr(9'h000, BASE, idx, lane), 1'b1);
    do_write(d, byte_w, idx, lane, tag);
    end_cycle();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 16'h0000;
    repeat (5) @(negedge clk);
    check(reply == 0 && dal_oe == 0 && dal_out == 0, "R1", "outputs during reset",
          {reply, dal_oe, dal_out}, 0);
    bus_init = 1'b0;
    repeat (3) @(negedge clk);
    check(reply == 0 && dal_oe == 0, "R1", "outputs after reset", {reply, dal_oe}, 0);
    read_word(3, "R1");

    // word write, then read with upper address bits set
    write_word(3, 16'h1234, 1'b0, 1'b0, "R7");
    addr_phase(mk_addr(9'h1FF, BASE, 3, 1'b0), 1'b1);
    do_read(model[3], "R3");
    end_cycle();

    // pattern across all words
    for (int i = 0; i < 16; i++) write_word(i, 16'(16'h0F11 * (i + 1) ^ 16'hA0A0), 1'b0, 1'b0, "R7");
    for (int i = 0; i < 16; i++) read_word(i, "R2");

    // byte lanes
    write_word(7, 16'hBEEF, 1'b0, 1'b0, "R7");
    write_word(7, 16'h55AA, 1'b1, 1'b1, "R8");
    read_word(7, "R8");
    write_word(7, 16'h1177, 1'b1, 1'b0, "R8");
    read_word(7, "R8");

    // qualifier missing
    addr_phase(mk_addr(9'h000, BASE, 7, 1'b0), 1'b0);
    expect_silent(1'b0, "R3");
    end_cycle();
    read_word(7, "R9");

    // window mismatch
    addr_phase(mk_addr(9'h000, BASE ^ 8'h01, 7, 1'b0), 1'b1);
    expect_silent(1'b0, "R4");
    expect_silent(1'b1, "R4");
    end_cycle();
    read_word(7, "R9");

    // claim ends with sync
    addr_phase(mk_addr(9'h000, BASE, 3, 1'b0), 1'b1);
    end_cycle();
    expect_silent(1'b1, "R10");

    // read-modify-write in one sync period
    addr_phase(mk_addr(9'h000, BASE, 9, 1'b0), 1'b1);
    do_read(model[9], "R12");
    do_write(16'h0F0F, 1'b0, 9, 1'b0, "R12");
    end_cycle();
    read_word(9, "R12");

    // reset during a held write reply
    begin
      bit got;
      bit back;
      addr_phase(mk_addr(9'h000, BASE, 5, 1'b0), 1'b1);
      @(negedge clk);
      dal_in = 22'h004321; bus_dout = 1'b1;
      wait_level(1'b1, 20, got);
      check(got, "R11", "write reply before reset", got, 1);
      bus_init = 1'b1;
      @(negedge clk);
      check(reply == 0 && dal_oe == 0, "R11", "reply and enable after reset",
            {reply, dal_oe}, 0);
      bus_init = 1'b0;
      back = 1'b0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (reply) back = 1'b1;
      end
      check(!back, "R11", "claim dropped by reset", back, 0);
      bus_dout = 1'b0;
      end_cycle();
      for (int i = 0; i < 16; i++) model[i] = 16'h0000;
      read_word(5, "R11");
      read_word(7, "R11");
    end

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R5", "all queued reads answered", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule